// File: doc/BRIEF.md
# Transfer Block Count Tracker

This block holds the block count and the block size for a data transfer between a card and its host, and counts the blocks down as the data engine finishes them. Software programs both values through one 32-bit word: the count sits in the upper half and the size in the low-order bits. The data engine reports each finished block with a one-cycle pulse. The block tells the engine how many blocks are left, and raises a one-cycle flag when the last block is done.

Counting takes place only when three inputs are all high: count-enable, multi-block select and transfer-active. In single-block mode the count field always reads back as 1. A programmed count of zero means no blocks, so finished-block pulses have no effect and no done flag appears. When a transfer stops at a block gap, the live count can still be read. A suspend command returns the count to the value that was last written.

Top module: `blk_count_tracker`

## Requirements
- R1: After reset the stored count and size are zero, so with multi-block select high the read value is 0x0000_0000, `remCount` is 0 and `doneFlag` is low.
- R2: A write while `xferActive` is low stores `wrData[31:16]` as the count and `wrData[12:0]` as the size. Read bits 15:13 are always zero.
- R3: A write while `xferActive` is high changes neither the count nor the size.
- R4: While `multiSel` is low, read bits 31:16 return 1, whatever count is stored.
- R5: A `blockDone` pulse while `cntEnable`, `multiSel` and `xferActive` are all high and the count is nonzero decrements the count by exactly one on that clock edge.
- R6: A `blockDone` pulse while any of `cntEnable`, `multiSel` or `xferActive` is low leaves the count unchanged.
- R7: `doneFlag` is high for exactly one cycle, the cycle right after the edge on which the count drops from 1 to 0.
- R8: While the count is zero, `blockDone` pulses leave it at zero and raise no `doneFlag`. A programmed count of zero therefore moves no blocks.
- R9: After `xferActive` falls, reads with `multiSel` high return the remaining count.
- R10: A `suspendCmd` pulse sets the count back to the value last written. It takes priority over a `blockDone` pulse or a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write value |
| cntEnable | input | 1 | Block-count enable |
| multiSel | input | 1 | Multi-block mode select |
| xferActive | input | 1 | Data transfer in progress |
| blockDone | input | 1 | One-cycle pulse per finished block |
| suspendCmd | input | 1 | One-cycle pulse when a suspend command is issued |
| remCount | output | 16 | Live stored block count |
| doneFlag | output | 1 | One-cycle pulse when the count reaches zero |
| rdData | output | 32 | Register read value |

## Verification
The bench programs every count from 0 to 5 and then sends two more finished-block pulses than the count. This catches a design that wraps below zero, fires the done flag on a zero count, or fires it a cycle late or for two cycles. It tries every combination of the three gating inputs except all-high, which exposes a design that counts with one of the gates missing. It stops a transfer part way and then issues a suspend, on its own and together with a finished-block pulse. A design that lets the decrement win over the suspend, or that reloads the remaining count instead of the programmed one, reads back the wrong value. Writes during an active transfer and reads in single-block mode are also compared against values the bench computes itself.

// File: rtl/blk_tracker_pkg.sv
package blk_tracker_pkg;
  typedef struct packed {
    logic loadWr;
    logic dec;
    logic restore;
  } dpStrobe_t;
endpackage

// File: rtl/blk_tracker_ctrl.sv
module blk_tracker_ctrl
  import blk_tracker_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      xferActive,
  input  logic      cntEnable,
  input  logic      multiSel,
  input  logic      blockDone,
  input  logic      suspendCmd,
  input  logic      cntIsZero,
  input  logic      cntIsOne,
  output dpStrobe_t st,
  output logic      doneFlag
);
  logic counting;

  assign counting = cntEnable & multiSel & xferActive;

  always_comb begin
    st.restore = suspendCmd;
    st.loadWr  = wrEn & ~xferActive & ~suspendCmd;
    st.dec     = blockDone & counting & ~cntIsZero & ~suspendCmd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneFlag <= 1'b0;
    else       doneFlag <= st.dec & cntIsOne;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |=> !doneFlag); // R7
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> cntIsZero); // R7
endmodule

// File: rtl/blk_tracker_dp.sv
module blk_tracker_dp
  import blk_tracker_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int SIZE_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  countQ,
  output logic [SIZE_W-1:0] sizeQ,
  output logic              cntIsZero,
  output logic              cntIsOne
);
  localparam int CNT_LSB = DATA_W - CNT_W;

  logic [CNT_W-1:0] shadowQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ  <= '0;
      sizeQ   <= '0;
      shadowQ <= '0;
    end else if (st.restore) begin
      countQ <= shadowQ;
    end else if (st.loadWr) begin
      countQ  <= wrData[DATA_W-1:CNT_LSB];
      shadowQ <= wrData[DATA_W-1:CNT_LSB];
      sizeQ   <= wrData[SIZE_W-1:0];
    end else if (st.dec) begin
      countQ <= countQ - 1'b1;
    end
  end

  assign cntIsZero = (countQ == '0);
  assign cntIsOne  = (countQ == CNT_W'(1));

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    st.dec && !st.restore |=> countQ == $past(countQ) - 1'b1); // R5
  AST_RESTORE_SHADOW: assert property (@(posedge clk) disable iff (!rstN)
    st.restore |=> countQ == $past(shadowQ)); // R10
  AST_ZERO_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    cntIsZero && !st.restore && !st.loadWr |=> cntIsZero); // R8
endmodule

// File: rtl/blk_count_tracker.sv
module blk_count_tracker
  import blk_tracker_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int SIZE_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cntEnable,
  input  logic              multiSel,
  input  logic              xferActive,
  input  logic              blockDone,
  input  logic              suspendCmd,
  output logic [CNT_W-1:0]  remCount,
  output logic              doneFlag,
  output logic [DATA_W-1:0] rdData
);
  localparam int CNT_LSB = DATA_W - CNT_W;

  dpStrobe_t         st;
  logic [CNT_W-1:0]  countQ;
  logic [SIZE_W-1:0] sizeQ;
  logic              cntIsZero;
  logic              cntIsOne;

  blk_tracker_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .xferActive(xferActive),
    .cntEnable(cntEnable), .multiSel(multiSel), .blockDone(blockDone),
    .suspendCmd(suspendCmd), .cntIsZero(cntIsZero), .cntIsOne(cntIsOne),
    .st(st), .doneFlag(doneFlag)
  );

  blk_tracker_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData),
    .countQ(countQ), .sizeQ(sizeQ), .cntIsZero(cntIsZero), .cntIsOne(cntIsOne)
  );

  always_comb begin
    rdData = '0;
    rdData[DATA_W-1:CNT_LSB] = multiSel ? countQ : CNT_W'(1);
    rdData[SIZE_W-1:0]       = sizeQ;
  end

  assign remCount = countQ;

  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    xferActive && !suspendCmd |=> $stable(rdData[SIZE_W-1:0])); // R3
  AST_SINGLE_READS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    !multiSel |-> rdData[DATA_W-1:CNT_LSB] == CNT_W'(1)); // R4
endmodule

// File: tb/blk_count_tracker_tb.sv
module blk_count_tracker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        cntEnable = 1'b0;
  logic        multiSel = 1'b1;
  logic        xferActive = 1'b0;
  logic        blockDone = 1'b0;
  logic        suspendCmd = 1'b0;
  logic [15:0] remCount;
  logic        doneFlag;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;

  blk_count_tracker u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .cntEnable(cntEnable), .multiSel(multiSel), .xferActive(xferActive),
    .blockDone(blockDone), .suspendCmd(suspendCmd),
    .remCount(remCount), .doneFlag(doneFlag), .rdData(rdData)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] v);
    @(negedge clk); wrEn = 1'b1; wrData = v;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulseDone();
    @(negedge clk); blockDone = 1'b1;
    @(negedge clk); blockDone = 1'b0;
  endtask

  task automatic pulseSuspend(input logic withDone);
    @(negedge clk); suspendCmd = 1'b1; blockDone = withDone;
    @(negedge clk); suspendCmd = 1'b0; blockDone = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 read", rdData, 32'h0);
    chk("R1 remCount", 32'(remCount), 32'h0);
    chk("R1 doneFlag", 32'(doneFlag), 32'h0);
    multiSel = 1'b0; #1;
    chk("R4 reset single", rdData, 32'h0001_0000);
    multiSel = 1'b1;

    // R2 field placement
    doWrite(32'h0005_0200);
    chk("R2 write", rdData, 32'h0005_0200);
    doWrite(32'h0003_FFFF);
    chk("R2 gap bits", rdData, 32'h0003_1FFF);
    multiSel = 1'b0; #1;
    chk("R4 single read", rdData, 32'h0001_1FFF);
    multiSel = 1'b1;

    // R3 write ignored while active
    @(negedge clk); xferActive = 1'b1;
    doWrite(32'h0009_0011);
    chk("R3 write blocked", rdData, 32'h0003_1FFF);
    @(negedge clk); xferActive = 1'b0;

    // R5 R7 R8 sweep of counts
    for (int n = 0; n <= 5; n++) begin
      doWrite({16'(n), 16'h0040});
      @(negedge clk); cntEnable = 1'b1; xferActive = 1'b1;
      for (int k = 0; k < n + 2; k++) begin
        pulseDone();
        chk("R5 R8 count", 32'(remCount), (n - k - 1 > 0) ? 32'(n - k - 1) : 32'h0);
        chk("R7 done pulse", 32'(doneFlag), (k == n - 1) ? 32'h1 : 32'h0);
        if (k == n - 1) begin
          @(negedge clk);
          chk("R7 done width", 32'(doneFlag), 32'h0);
        end
      end
      @(negedge clk); cntEnable = 1'b0; xferActive = 1'b0;
    end

    // R6 gating combinations
    for (int c = 0; c < 7; c++) begin
      doWrite(32'h0003_0000);
      @(negedge clk);
      cntEnable = c[0]; multiSel = c[1]; xferActive = c[2];
      pulseDone();
      chk("R6 gated", 32'(remCount), 32'h3);
      chk("R6 no done", 32'(doneFlag), 32'h0);
      @(negedge clk);
      cntEnable = 1'b0; multiSel = 1'b1; xferActive = 1'b0;
    end

    // R9 stop at block gap, then R10 suspend
    doWrite(32'h0004_0010);
    @(negedge clk); cntEnable = 1'b1; xferActive = 1'b1;
    pulseDone();
    pulseDone();
    @(negedge clk); xferActive = 1'b0;
    @(negedge clk);
    chk("R9 live count", rdData, 32'h0002_0010);
    pulseSuspend(1'b0);
    chk("R10 restore", 32'(remCount), 32'h4);

    // R10 suspend wins over blockDone
    @(negedge clk); xferActive = 1'b1;
    pulseDone();
    chk("R5 after restore", 32'(remCount), 32'h3);
    pulseSuspend(1'b1);
    chk("R10 priority", 32'(remCount), 32'h4);
    chk("R10 no done", 32'(doneFlag), 32'h0);
    @(negedge clk); xferActive = 1'b0; cntEnable = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule